// File: doc/BRIEF.md
# Double Precision Floating-Point Relational Comparator

This block takes two 64-bit binary floating-point operands and reports how they relate. It raises exactly one of four flags: the first operand is greater, the first operand is less, the two are equal, or the pair is unordered because a NaN is involved. The block is meant for use in sort networks, min/max selection and the compare path of a floating-point unit.

Inside, each operand is first decoded into sign, biased exponent and fraction, and its value class is found. The unsigned magnitudes (exponent bits above fraction bits, 63 bits) go to a logarithmic prefix tree of (greater, equal) pairs. The tree finds the most significant bit where the two magnitudes differ. A resolution stage then applies the signs, treats the two signed zeros as the same value, and lets a NaN override every other result. A parameter can place a register on the four flags to ease timing. The default build has this register, which adds one cycle of latency.

Top module: `fp_compare_dp`

## Requirements
- R1: An operand is a NaN when its exponent field (bits 62:52) is all ones and its fraction field (bits 51:0) is non-zero, whatever its sign bit. This covers both quiet payloads (fraction bit 51 set) and signalling payloads (bit 51 clear). If either operand is a NaN, `un_o` is high and `gt_o`, `lt_o` and `eq_o` are low.
- R2: Once the first result after reset has been loaded, exactly one of `gt_o`, `lt_o`, `eq_o` and `un_o` is high on every cycle.
- R3: Positive zero and negative zero (exponent and fraction all zero, either sign) compare equal to each other in all four sign combinations.
- R4: An operand with an all-ones exponent and a zero fraction is an infinity. It is ordered like any other value: +inf is greater than every finite value, -inf is less than every finite value, and two infinities of the same sign are equal.
- R5: Operands with a zero exponent and a non-zero fraction (denormals) compare by their magnitude. They order correctly against zeros, against each other and against normal numbers.
- R6: When the two signs differ and the operands are not both zeros, the operand whose sign bit is 0 is the greater.
- R7: When both sign bits are 1, the operand with the larger magnitude is the lesser.
- R8: When both sign bits are 0, the result follows the unsigned order of bits 62:0. A difference in a more significant bit decides the result no matter what the lower bits hold.
- R9: Two non-NaN operands with identical bit patterns give `eq_o`.
- R10: With the output register enabled (OUT_REG=1, the default), the flags show the relation of the operands sampled at the previous rising edge of `clk`. While `rst` is high, all four flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | 64 | First operand: sign bit 63, exponent 62:52, fraction 51:0 |
| op_b | input | 64 | Second operand, same layout |
| gt_o | output | 1 | op_a is greater than op_b |
| lt_o | output | 1 | op_a is less than op_b |
| eq_o | output | 1 | op_a equals op_b |
| un_o | output | 1 | At least one operand is a NaN |

## Verification
Two decisions meet in one cycle and must be resolved by priority: the sign correction, which flips or overrides the magnitude result, and the special-value override (NaN makes the pair unordered; a pair of zeros makes it equal). The bench sets up such collisions on purpose. It pairs NaNs of either sign with negative and positive operands. It pairs zeros of opposite sign, whose magnitudes match but whose signs differ. It pairs negative denormals against negative zero. Each result is judged against a reference that turns the operands into real numbers and applies ordinary real comparison, in which any NaN makes greater, less and equal all false.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int EXP_W = 11;
    localparam int MAN_W = 52;
    localparam int MAG_W = EXP_W + MAN_W;
    localparam int FP_W  = MAG_W + 1;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [MAN_W-1:0] frac;
    } fp_word_t;

    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_DENORM = 3'd1,
        CLS_NORMAL = 3'd2,
        CLS_INF    = 3'd3,
        CLS_NAN    = 3'd4
    } fp_class_e;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
        logic un;
    } fp_rel_t;

    function automatic fp_class_e classify(input fp_word_t w);
        logic exp_ones;
        logic exp_zero;
        logic frac_zero;
        exp_ones  = &w.expo;
        exp_zero  = ~|w.expo;
        frac_zero = ~|w.frac;
        if (exp_ones)
            return frac_zero ? CLS_INF : CLS_NAN;
        else if (exp_zero)
            return frac_zero ? CLS_ZERO : CLS_DENORM;
        else
            return CLS_NORMAL;
    endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
(
    input  logic [FP_W-1:0]  word_i,
    output logic             sign_o,
    output logic [MAG_W-1:0] mag_o,
    output fp_class_e        cls_o
);
    fp_word_t w;

    assign w      = fp_word_t'(word_i);
    assign sign_o = w.sign;
    assign mag_o  = {w.expo, w.frac};
    assign cls_o  = classify(w);

endmodule

// File: rtl/fpcmp_prefix_tree.sv
module fpcmp_prefix_tree #(
    parameter int W = 63
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         gt_o,
    output logic         eq_o
);
    localparam int LV  = (W > 1) ? $clog2(W) : 1;
    localparam int N   = 1 << LV;
    localparam int PAD = N - W;

    // Leaf pairs; padding sits below the LSB and is neutral (equal, not greater).
    logic [N-1:0] leaf_g;
    logic [N-1:0] leaf_e;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_leaf
            if (gi < PAD) begin : g_pad
                assign leaf_g[gi] = 1'b0;
                assign leaf_e[gi] = 1'b1;
            end else begin : g_bit
                assign leaf_g[gi] = a_i[gi-PAD] & ~b_i[gi-PAD];
                assign leaf_e[gi] = ~(a_i[gi-PAD] ^ b_i[gi-PAD]);
            end
        end
    endgenerate

    logic [N-1:0] tg [0:LV];
    logic [N-1:0] te [0:LV];

    always_comb begin
        tg[0] = leaf_g;
        te[0] = leaf_e;
        for (int lv = 0; lv < LV; lv++) begin
            tg[lv+1] = '0;
            te[lv+1] = '0;
            for (int j = 0; j < (N >> (lv + 1)); j++) begin
                // high half wins unless it is equal, then low half decides
                tg[lv+1][j] = tg[lv][2*j+1] | (te[lv][2*j+1] & tg[lv][2*j]);
                te[lv+1][j] = te[lv][2*j+1] & te[lv][2*j];
            end
        end
    end

    assign gt_o = tg[LV][0];
    assign eq_o = te[LV][0];

endmodule

// File: rtl/fpcmp_resolve.sv
module fpcmp_resolve
    import fpcmp_pkg::*;
(
    input  logic      sign_a_i,
    input  logic      sign_b_i,
    input  fp_class_e cls_a_i,
    input  fp_class_e cls_b_i,
    input  logic      mag_gt_i,
    input  logic      mag_eq_i,
    output fp_rel_t   rel_o
);
    logic any_nan;
    logic both_zero;
    logic mag_lt;

    assign any_nan   = (cls_a_i == CLS_NAN) || (cls_b_i == CLS_NAN);
    assign both_zero = (cls_a_i == CLS_ZERO) && (cls_b_i == CLS_ZERO);
    assign mag_lt    = ~mag_gt_i & ~mag_eq_i;

    always_comb begin
        rel_o = '0;
        if (any_nan) begin
            rel_o.un = 1'b1;
        end else if (both_zero) begin
            rel_o.eq = 1'b1;
        end else if (sign_a_i != sign_b_i) begin
            rel_o.gt = ~sign_a_i;
            rel_o.lt = sign_a_i;
        end else if (!sign_a_i) begin
            rel_o.gt = mag_gt_i;
            rel_o.lt = mag_lt;
            rel_o.eq = mag_eq_i;
        end else begin
            rel_o.gt = mag_lt;
            rel_o.lt = mag_gt_i;
            rel_o.eq = mag_eq_i;
        end
    end

endmodule

// File: rtl/fp_compare_dp.sv
module fp_compare_dp
    import fpcmp_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    output logic        gt_o,
    output logic        lt_o,
    output logic        eq_o,
    output logic        un_o
);
    logic [FP_W-1:0]  word   [2];
    logic             sgn    [2];
    logic [MAG_W-1:0] mag    [2];
    fp_class_e        cls    [2];
    logic             mag_gt;
    logic             mag_eq;
    fp_rel_t          rel_d;
    fp_rel_t          rel_q;

    assign word[0] = op_a;
    assign word[1] = op_b;

    genvar k;
    generate
        for (k = 0; k < 2; k++) begin : g_opnd
            fpcmp_classify u_cls (
                .word_i (word[k]),
                .sign_o (sgn[k]),
                .mag_o  (mag[k]),
                .cls_o  (cls[k])
            );
        end
    endgenerate

    fpcmp_prefix_tree #(.W(MAG_W)) u_tree (
        .a_i  (mag[0]),
        .b_i  (mag[1]),
        .gt_o (mag_gt),
        .eq_o (mag_eq)
    );

    fpcmp_resolve u_res (
        .sign_a_i (sgn[0]),
        .sign_b_i (sgn[1]),
        .cls_a_i  (cls[0]),
        .cls_b_i  (cls[1]),
        .mag_gt_i (mag_gt),
        .mag_eq_i (mag_eq),
        .rel_o    (rel_d)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) rel_q <= '0;
                else     rel_q <= rel_d;
            end
        end else begin : g_comb
            assign rel_q = rel_d;
        end
    endgenerate

    assign gt_o = rel_q.gt;
    assign lt_o = rel_q.lt;
    assign eq_o = rel_q.eq;
    assign un_o = rel_q.un;

endmodule

// File: rtl/fp_compare_dp_chk.sv
module fp_compare_dp_chk #(
    parameter bit LAT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic [63:0] op_a,
    input logic [63:0] op_b,
    input logic        gt_o,
    input logic        lt_o,
    input logic        eq_o,
    input logic        un_o
);
    logic [63:0] a_d, b_d;
    logic [63:0] va, vb;
    logic        seen;

    always_ff @(posedge clk) begin
        a_d  <= op_a;
        b_d  <= op_b;
        seen <= ~rst;
    end

    generate
        if (LAT) begin : g_lat
            assign va = a_d;
            assign vb = b_d;
        end else begin : g_now
            assign va = op_a;
            assign vb = op_b;
        end
    endgenerate

    logic nan_a, nan_b, zero_a, zero_b;
    assign nan_a  = (va[62:52] == 11'h7FF) && (va[51:0] != 52'd0);
    assign nan_b  = (vb[62:52] == 11'h7FF) && (vb[51:0] != 52'd0);
    assign zero_a = (va[62:0] == 63'd0);
    assign zero_b = (vb[62:0] == 63'd0);

    // R1
    a_r1_nan_unordered: assert property (@(posedge clk) disable iff (rst)
        seen |-> (un_o == (nan_a || nan_b)));
    // R2
    a_r2_one_flag: assert property (@(posedge clk) disable iff (rst)
        seen |-> $onehot({gt_o, lt_o, eq_o, un_o}));
    // R3
    a_r3_zeros_equal: assert property (@(posedge clk) disable iff (rst)
        (seen && zero_a && zero_b) |-> eq_o);
    // R6
    a_r6_sign_decides: assert property (@(posedge clk) disable iff (rst)
        (seen && !nan_a && !nan_b && (va[63] != vb[63]) && !(zero_a && zero_b))
        |-> (gt_o == !va[63]) && (lt_o == va[63]));
    // R9
    a_r9_same_bits_equal: assert property (@(posedge clk) disable iff (rst)
        (seen && !nan_a && (va == vb)) |-> eq_o);
    // R10
    a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
        (LAT && $past(rst)) |-> !(gt_o || lt_o || eq_o || un_o));

endmodule

bind fp_compare_dp fp_compare_dp_chk #(.LAT(OUT_REG)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .op_a (op_a),
    .op_b (op_b),
    .gt_o (gt_o),
    .lt_o (lt_o),
    .eq_o (eq_o),
    .un_o (un_o)
);

// File: tb/sim_fp_compare_dp.sv
module sim_fp_compare_dp;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        gt_o, lt_o, eq_o, un_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    fp_compare_dp u0 (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
        .gt_o(gt_o), .lt_o(lt_o), .eq_o(eq_o), .un_o(un_o)
    );

    localparam logic [63:0] PZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] NQNAN = 64'hFFF8_0000_0000_1234;
    localparam logic [63:0] PMAX  = 64'h7FEF_FFFF_FFFF_FFFF;
    localparam logic [63:0] NMAX  = 64'hFFEF_FFFF_FFFF_FFFF;
    localparam logic [63:0] PDEN1 = 64'h0000_0000_0000_0001;
    localparam logic [63:0] PDEN2 = 64'h0000_0000_0000_0002;
    localparam logic [63:0] PDENH = 64'h000F_FFFF_FFFF_FFFF;
    localparam logic [63:0] PMINN = 64'h0010_0000_0000_0000;
    localparam logic [63:0] NDEN1 = 64'h8000_0000_0000_0001;
    localparam logic [63:0] NDEN2 = 64'h8000_0000_0000_0002;
    localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO   = 64'h4000_0000_0000_0000;
    localparam logic [63:0] MONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] MTWO  = 64'hC000_0000_0000_0000;

    // Reference: real-number semantics; NaN makes every relation false.
    function automatic logic [3:0] ref_rel(input logic [63:0] a, input logic [63:0] b);
        real ra, rb;
        logic g, l, e;
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        g = (ra > rb);
        l = (ra < rb);
        e = (ra == rb);
        return {g, l, e, !(g || l || e)};
    endfunction

    task automatic check_now(input logic [3:0] exp_v, input string tag);
        logic [3:0] act;
        act = {gt_o, lt_o, eq_o, un_o};
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h got gt/lt/eq/un=%b expected %b",
                     tag, op_a, op_b, act, exp_v);
        end
    endtask

    // Called just after a falling edge: drive, let one rising edge pass, check.
    task automatic apply(input logic [63:0] a, input logic [63:0] b, input string tag);
        op_a = a;
        op_b = b;
        @(negedge clk);
        check_now(ref_rel(a, b), tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic [63:0] ra, rb;
        repeat (3) @(negedge clk);
        check_now(4'b0000, "R10 reset clears flags");
        rst = 1'b0;
        @(negedge clk);

        // R1: NaN in either position, quiet and signalling, either sign
        apply(QNAN, ONE, "R1 qnan a");
        apply(MONE, SNAN, "R1 snan b");
        apply(NQNAN, NINF, "R1 neg nan vs -inf");
        apply(SNAN, QNAN, "R1 nan vs nan");
        apply(QNAN, QNAN, "R1 same nan bits");
        apply(PZERO, NQNAN, "R1 zero vs nan");
        // R3: signed zeros
        apply(PZERO, NZERO, "R3 +0 -0");
        apply(NZERO, PZERO, "R3 -0 +0");
        apply(NZERO, NZERO, "R3 -0 -0");
        apply(PZERO, PZERO, "R3 +0 +0");
        // R4: infinities
        apply(PINF, PMAX, "R4 +inf > max");
        apply(NINF, NMAX, "R4 -inf < -max");
        apply(PINF, PINF, "R4 +inf == +inf");
        apply(NINF, NINF, "R4 -inf == -inf");
        apply(NINF, PINF, "R4 -inf < +inf");
        apply(PDEN1, NINF, "R4 denorm > -inf");
        // R5: denormals
        apply(PDEN1, PDEN2, "R5 den1 < den2");
        apply(PDEN1, NZERO, "R5 den > -0");
        apply(NDEN1, NZERO, "R5 -den < -0");
        apply(PDENH, PMINN, "R5 max den < min normal");
        apply(NDEN2, NDEN1, "R5 -den2 < -den1");
        // R6: sign decides
        apply(PDEN1, MTWO, "R6 pos > neg");
        apply(NZERO, PDEN1, "R6 -0 < +den");
        apply(NMAX, PZERO, "R6 neg < +0");
        // R7: both negative
        apply(MTWO, MONE, "R7 -2 < -1");
        apply(MONE, MTWO, "R7 -1 > -2");
        // R8: MSB priority
        apply(TWO, 64'h3FFF_FFFF_FFFF_FFFF, "R8 exponent outranks fraction");
        apply(64'h0008_0000_0000_0000, PDENH & 64'h0007_FFFF_FFFF_FFFF, "R8 top fraction bit");
        apply(ONE, TWO, "R8 1 < 2");
        // R9: identical bits
        apply(PMAX, PMAX, "R9 same max");
        apply(NDEN1, NDEN1, "R9 same neg den");

        // R10: output holds until the next rising edge
        op_a = ONE; op_b = TWO;
        @(negedge clk);
        op_a = TWO; op_b = ONE;
        #5;
        check_now(4'b0100, "R10 holds previous result");
        @(negedge clk);
        check_now(4'b1000, "R10 new result after edge");

        // Random pairs, with special exponents and shared magnitudes mixed in
        for (int i = 0; i < 3000; i++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            case (i % 6)
                1: rb = {~ra[63], ra[62:0]};
                2: rb = ra;
                3: begin ra[62:52] = 11'h7FF; rb[62:52] = 11'd0; end
                4: begin ra[62:52] = 11'd0; rb[62:40] = {11'd0, ra[51:40]}; end
                5: rb[62:52] = ra[62:52];
                default: ;
            endcase
            apply(ra, rb, "R2 R8 random pair");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule